// File: doc/BRIEF.md
# NAND Page Read Command Sequencer

This block is the host-side read engine for an 8-bit parallel NAND flash. A host places one read request on a request/acknowledge port. The block then produces the matching bus cycles on the flash pins. Command bytes go out with the command-latch strobe and address bytes with the address-latch strobe, each framed by a write-enable pulse. After a page load the block waits for the flash to report ready. It then clocks data bytes in with read-enable pulses and hands them to the host over a valid/ready byte stream.

Five request kinds are supported: a plain page read, a column jump within the page already loaded, a sequential cache read, a random cache read and a cache-read exit. The block keeps track of three things: whether a page has been loaded, whether a cache sequence is open, and which row is being fetched behind the data now streaming. With that state it refuses requests that break the ordering rules, and it refuses any further cache read once the last page of the device has been fetched. A refused request produces a one-cycle error pulse instead of bus traffic. Strobe widths and the delay before busy is sampled are cycle counts set by parameters.

Top module: `nand_read_seq`

## Requirements
- R1: During and after reset, with no request running, ce_n, we_n and re_n are high, out_valid and err are low, and req_ready is high.
- R2: A page read (req_op 0) issues, in this order: command 0x00 with cle high, five address bytes with ale high (column low byte, column high byte, then row bits 7:0, 15:8 and 23:16), and command 0x30 with cle high. cle and ale are never high together.
- R3: After a load confirm (0x30, 0x31 or 0x3F), the block waits BUSY_WAIT_CYC cycles. It then waits until the synchronised rb input is high before the first read-enable pulse. It streams one byte per pulse, starting at the start column and running to the final spare byte (column MAIN_BYTES+SPARE_BYTES-1). out_last is high only on that final byte. A page read streams from req_col.
- R4: A column jump (req_op 1) issues command 0x05, the two column address bytes and command 0xE0. It skips the busy wait and streams the page currently in the output register from req_col to the end of that page.
- R5: A sequential cache read (req_op 2) issues only command 0x31. It streams the previously loaded page from column 0. The row fetched behind that stream is the previous row plus one.
- R6: A random cache read (req_op 3) issues command 0x00, column bytes 0x00 and 0x00, the three row bytes of req_row, and then command 0x31. It streams the previously loaded page from column 0. The row fetched behind that stream is req_row.
- R7: A cache exit (req_op 4) issues only command 0x3F, streams the last fetched page from column 0, and closes the cache sequence.
- R8: The following requests are illegal: a cache read without a prior page read; a cache read after an exit; a cache read when the last fetched row is PAGES-1; any row at or above PAGES; a column at or above the page size; a column jump before any page has loaded; an exit while no cache sequence is open. For an illegal request, err is high for the one cycle after acceptance, no bus cycle is issued and req_ready stays high.
- R9: Every write-enable low pulse lasts exactly WE_CYC clock cycles and every read-enable low pulse lasts exactly RE_CYC clock cycles.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_op | input | 3 | 0 page read, 1 column jump, 2 sequential cache, 3 random cache, 4 cache exit |
| req_row | input | 24 | Page row address |
| req_col | input | 16 | Start column |
| err | output | 1 | One-cycle pulse for a refused request |
| out_valid | output | 1 | Data byte present |
| out_ready | input | 1 | Host takes the byte |
| out_data | output | 8 | Data byte |
| out_last | output | 1 | Final byte of the page |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| we_n | output | 1 | Write enable, active low |
| re_n | output | 1 | Read enable, active low |
| io_out | output | 8 | Byte driven onto the flash bus |
| io_oe | output | 1 | Drive enable for io_out |
| io_in | input | 8 | Byte read from the flash bus |
| rb | input | 1 | Ready/busy from the flash, high when ready |

## Verification
The bench builds the block with a four-page device of eight main and four spare bytes, two-cycle strobes and a three-cycle busy wait. With so few pages, a handful of sequential cache reads reaches the last row, so the end-of-device refusal and the exit fetch of the final page are both exercised. The twelve-byte page puts every stream boundary within a short run: the join between main and spare, a single-byte stream from the last column, and an out-of-range column. A flash model in the bench answers busy and serves row- and column-dependent bytes, and the host side applies periodic back-pressure.

// File: rtl/nand_read_seq.sv
module nand_read_seq #(
  parameter int PAGES         = 1024,
  parameter int MAIN_BYTES    = 2048,
  parameter int SPARE_BYTES   = 64,
  parameter int WE_CYC        = 2,
  parameter int RE_CYC        = 2,
  parameter int BUSY_WAIT_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [23:0] req_row,
  input  logic [15:0] req_col,
  output logic        err,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        ce_n,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  io_out,
  output logic        io_oe,
  input  logic [7:0]  io_in,
  input  logic        rb
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam logic [15:0] PB_LAST  = 16'(PAGE_BYTES - 1);
  localparam logic [23:0] ROW_LAST = 24'(PAGES - 1);
  localparam logic [15:0] WE_LAST  = 16'(WE_CYC - 1);
  localparam logic [15:0] RE_LAST  = 16'(RE_CYC - 1);
  localparam logic [15:0] BW_LAST  = 16'(BUSY_WAIT_CYC - 1);
  localparam logic [2:0] OP_READ = 3'd0, OP_RCOL = 3'd1, OP_CSEQ = 3'd2,
                         OP_CRND = 3'd3, OP_CEXIT = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_WAIT, S_RLO, S_HOLD, S_RHI} st_t;

  st_t st;
  logic [2:0]  op_q, step;
  logic [23:0] row_q, lrow;
  logic [15:0] col_q, dcol, cnt;
  logic        armed, have_page, cache_on, rb_s1, rb_s2, ok;
  logic [9:0]  cur;

  function automatic logic [9:0] wstep(input logic [2:0] op, input logic [2:0] idx,
                                       input logic [23:0] row, input logic [15:0] col);
    logic [7:0] conf;
    conf  = (op == OP_CRND) ? 8'h31 : 8'h30;
    wstep = '0;
    case (op)
      OP_READ, OP_CRND:
        case (idx)
          3'd0: wstep = {2'b10, 8'h00};
          3'd1: wstep = {2'b01, col[7:0]};
          3'd2: wstep = {2'b01, col[15:8]};
          3'd3: wstep = {2'b01, row[7:0]};
          3'd4: wstep = {2'b01, row[15:8]};
          3'd5: wstep = {2'b01, row[23:16]};
          default: wstep = {2'b10, conf};
        endcase
      OP_RCOL:
        case (idx)
          3'd0: wstep = {2'b10, 8'h05};
          3'd1: wstep = {2'b01, col[7:0]};
          3'd2: wstep = {2'b01, col[15:8]};
          default: wstep = {2'b10, 8'hE0};
        endcase
      OP_CSEQ: wstep = {2'b10, 8'h31};
      default: wstep = {2'b10, 8'h3F};
    endcase
  endfunction

  function automatic logic [2:0] last_step(input logic [2:0] op);
    case (op)
      OP_READ, OP_CRND: last_step = 3'd6;
      OP_RCOL:          last_step = 3'd3;
      default:          last_step = 3'd0;
    endcase
  endfunction

  always_comb begin
    ok = 1'b0;
    case (req_op)
      OP_READ:  ok = ({1'b0, req_row} < 25'(PAGES)) && ({1'b0, req_col} < 17'(PAGE_BYTES));
      OP_RCOL:  ok = have_page && ({1'b0, req_col} < 17'(PAGE_BYTES));
      OP_CSEQ:  ok = armed && (lrow != ROW_LAST);
      OP_CRND:  ok = armed && (lrow != ROW_LAST) && ({1'b0, req_row} < 25'(PAGES));
      OP_CEXIT: ok = cache_on;
      default:  ok = 1'b0;
    endcase
  end

  assign cur       = wstep(op_q, step, row_q, col_q);
  assign io_oe     = (st == S_WLO) || (st == S_WHI);
  assign cle       = io_oe & cur[9];
  assign ale       = io_oe & cur[8];
  assign io_out    = cur[7:0];
  assign we_n      = (st != S_WLO);
  assign re_n      = (st != S_RLO);
  assign ce_n      = (st == S_IDLE);
  assign req_ready = (st == S_IDLE);
  assign out_valid = (st == S_HOLD);
  assign out_last  = out_valid && (dcol == PB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; step <= '0; row_q <= '0; col_q <= '0; dcol <= '0;
      cnt <= '0; lrow <= '0; armed <= 1'b0; have_page <= 1'b0; cache_on <= 1'b0;
      rb_s1 <= 1'b0; rb_s2 <= 1'b0; err <= 1'b0; out_data <= '0;
    end else begin
      rb_s1 <= rb;
      rb_s2 <= rb_s1;
      err   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (!ok) err <= 1'b1;
          else begin
            op_q <= req_op; row_q <= req_row; step <= '0; cnt <= '0; st <= S_WLO;
            col_q <= (req_op == OP_READ || req_op == OP_RCOL) ? req_col : 16'd0;
            dcol  <= (req_op == OP_READ || req_op == OP_RCOL) ? req_col : 16'd0;
            case (req_op)
              OP_READ: begin armed <= 1'b1; have_page <= 1'b1; cache_on <= 1'b0; lrow <= req_row; end
              OP_CSEQ: begin lrow <= lrow + 24'd1; cache_on <= 1'b1; end
              OP_CRND: begin lrow <= req_row; cache_on <= 1'b1; end
              OP_CEXIT: begin cache_on <= 1'b0; armed <= 1'b0; end
              default: ;
            endcase
          end
        end
        S_WLO: if (cnt == WE_LAST) begin cnt <= '0; st <= S_WHI; end else cnt <= cnt + 16'd1;
        S_WHI: if (cnt == WE_LAST) begin
          cnt  <= '0;
          step <= step + 3'd1;
          if (step == last_step(op_q)) st <= (op_q == OP_RCOL) ? S_RLO : S_WAIT;
          else st <= S_WLO;
        end else cnt <= cnt + 16'd1;
        S_WAIT: if (cnt != BW_LAST) cnt <= cnt + 16'd1;
                else if (rb_s2) begin cnt <= '0; st <= S_RLO; end
        S_RLO: if (cnt == RE_LAST) begin cnt <= '0; out_data <= io_in; st <= S_HOLD; end
               else cnt <= cnt + 16'd1;
        S_HOLD: if (out_ready) begin
          if (dcol == PB_LAST) st <= S_IDLE;
          else begin dcol <= dcol + 16'd1; st <= S_RHI; end
        end
        S_RHI: if (cnt == RE_LAST) begin cnt <= '0; st <= S_RLO; end else cnt <= cnt + 16'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && we_n && re_n && !out_valid));
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  p_read_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n) !re_n |-> rb_s2);
  p_cache_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && cle && io_out == 8'h31) |-> armed);
  p_err_no_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (we_n && re_n && req_ready));
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: tb/nand_read_seq_tb_top.sv
module nand_read_seq_tb_top;
  localparam int PG = 4, MB = 8, SB = 4, PB = MB + SB, WEC = 2, REC = 2, BWC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, out_ready = 1'b1, rb = 1'b1;
  logic [2:0] req_op = '0;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic req_ready, err, out_valid, out_last, ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0] out_data, io_out, io_in;

  always #5 clk = ~clk;

  nand_read_seq #(.PAGES(PG), .MAIN_BYTES(MB), .SPARE_BYTES(SB), .WE_CYC(WEC),
                  .RE_CYC(REC), .BUSY_WAIT_CYC(BWC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_row(req_row), .req_col(req_col), .err(err),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in), .rb(rb));

  int vecs = 0, miss = 0;
  bit started = 0, ended = 0;
  string cur_tag = "R1";

  task automatic fail(string tag, string what, int act, int exp);
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    miss++;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) fail(tag, what, act, exp);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  function automatic logic [7:0] fb(int r, int c);
    return 8'(r * 37 + c * 5 + 27);
  endfunction

  // flash device model
  logic [7:0] abuf [5];
  int acnt = 0, d_row = 0, o_row = 0, o_col = 0, we_low = 0, re_low = 0;
  logic [9:0] bus_q [$];
  assign io_in = fb(o_row, o_col);

  task automatic go_busy();
    rb = 1'b0;
    fork begin repeat (8) @(posedge clk); rb = 1'b1; end join_none
  endtask

  always @(posedge we_n) if (started) begin
    logic [9:0] e;
    int arow, acol;
    check("R9", "we_n low width", we_low, WEC);
    we_low = 0;
    vecs++;
    if (bus_q.size() == 0) fail(cur_tag, "unexpected bus cycle", int'({cle, ale, io_out}), 0);
    else begin
      e = bus_q.pop_front();
      if ({cle, ale, io_out} !== e) fail(cur_tag, "bus cycle", int'({cle, ale, io_out}), int'(e));
    end
    acol = int'({abuf[1], abuf[0]});
    arow = int'({abuf[4], abuf[3], abuf[2]});
    if (cle) begin
      case (io_out)
        8'h00, 8'h05: acnt = 0;
        8'h30: begin d_row = arow; o_row = d_row; o_col = acol; acnt = 0; go_busy(); end
        8'h31: begin
          o_row = d_row;
          d_row = (acnt == 5) ? arow : d_row + 1;
          o_col = 0; acnt = 0; go_busy();
        end
        8'h3F: begin o_row = d_row; o_col = 0; go_busy(); end
        8'hE0: begin o_col = acol; acnt = 0; end
        default: ;
      endcase
    end else if (ale) begin
      if (acnt < 5) abuf[acnt] = io_out;
      acnt++;
    end
  end

  always @(posedge re_n) if (started) begin
    check("R9", "re_n low width", re_low, REC);
    re_low = 0;
    o_col++;
  end

  always @(negedge clk) if (started) begin
    if (!we_n) we_low++;
    if (!re_n) re_low++;
    if (!re_n && !rb) fail("R3", "read strobe while busy", 1, 0);
  end

  // host stream side
  logic [7:0] exp_q [$];
  bit last_q [$];
  int k = 0;
  bit held = 0;
  logic [7:0] held_d = '0;
  bit held_l = 0;

  always @(negedge clk) begin
    k++;
    out_ready = (k % 5) != 2;
    #1;
    if (started && out_valid) begin
      if (held) begin
        check("R10", "held data", int'(out_data), int'(held_d));
        check("R10", "held last", int'(out_last), int'(held_l));
      end
      if (out_ready) begin
        held = 0;
        vecs++;
        if (exp_q.size() == 0) fail(cur_tag, "unexpected byte", int'(out_data), 0);
        else begin
          logic [7:0] ed;
          bit el;
          ed = exp_q.pop_front();
          el = last_q.pop_front();
          if (out_data !== ed) fail(cur_tag, "data byte", int'(out_data), int'(ed));
          check(cur_tag, "out_last", int'(out_last), int'(el));
        end
      end else begin
        held = 1; held_d = out_data; held_l = out_last;
      end
    end else held = 0;
  end

  // reference model of the request rules
  bit m_armed = 0, m_have = 0, m_cache = 0;
  int m_lrow = 0, m_orow = 0;

  task automatic push_bus(bit c, bit a, logic [7:0] b);
    bus_q.push_back({c, a, b});
  endtask

  task automatic push_page(int r, int c0);
    for (int c = c0; c < PB; c++) begin
      exp_q.push_back(fb(r, c));
      last_q.push_back(c == PB - 1);
    end
  endtask

  task automatic push_addr(int row, int col);
    push_bus(0, 1, 8'(col)); push_bus(0, 1, 8'(col >> 8));
    push_bus(0, 1, 8'(row)); push_bus(0, 1, 8'(row >> 8)); push_bus(0, 1, 8'(row >> 16));
  endtask

  task automatic do_req(int op, int row, int col, string tag);
    bit legal;
    cur_tag = tag;
    case (op)
      0: legal = row < PG && col < PB;
      1: legal = m_have && col < PB;
      2: legal = m_armed && m_lrow != PG - 1;
      3: legal = m_armed && m_lrow != PG - 1 && row < PG;
      default: legal = m_cache;
    endcase
    if (legal) begin
      case (op)
        0: begin
          push_bus(1, 0, 8'h00); push_addr(row, col); push_bus(1, 0, 8'h30);
          push_page(row, col);
          m_armed = 1; m_have = 1; m_cache = 0; m_lrow = row; m_orow = row;
        end
        1: begin
          push_bus(1, 0, 8'h05); push_bus(0, 1, 8'(col)); push_bus(0, 1, 8'(col >> 8));
          push_bus(1, 0, 8'hE0); push_page(m_orow, col);
        end
        2: begin
          push_bus(1, 0, 8'h31); m_orow = m_lrow; m_lrow++; m_cache = 1; push_page(m_orow, 0);
        end
        3: begin
          push_bus(1, 0, 8'h00); push_addr(row, 0); push_bus(1, 0, 8'h31);
          m_orow = m_lrow; m_lrow = row; m_cache = 1; push_page(m_orow, 0);
        end
        default: begin
          push_bus(1, 0, 8'h3F); m_orow = m_lrow; m_cache = 0; m_armed = 0; push_page(m_orow, 0);
        end
      endcase
    end
    @(negedge clk);
    req_op = 3'(op); req_row = 24'(row); req_col = 16'(col); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, "err pulse", int'(err), legal ? 0 : 1);
    if (!legal) begin
      check("R8", "ready after refusal", int'(req_ready), 1);
      @(negedge clk);
      check("R8", "err one cycle", int'(err), 0);
      check("R8", "no bus after refusal", int'(ce_n), 1);
    end else begin
      do @(negedge clk); while (!(req_ready && exp_q.size() == 0));
      check(tag, "bus cycles left", bus_q.size(), 0);
      check("R1", "idle strobes", int'({ce_n, we_n, re_n}), 7);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail("R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ce/we/re", int'({ce_n, we_n, re_n}), 7);
    check("R1", "reset out_valid", int'(out_valid), 0);
    check("R1", "reset err", int'(err), 0);
    check("R1", "reset req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    started = 1;
    repeat (2) @(negedge clk);
    check("R1", "idle after reset", int'({ce_n, we_n, re_n, out_valid}), 14);

    do_req(2, 0, 0, "R8");
    do_req(1, 0, 2, "R8");
    do_req(4, 0, 0, "R8");
    do_req(0, 5, 0, "R8");
    do_req(0, 1, 3, "R2");
    do_req(1, 0, 9, "R4");
    do_req(1, 0, 12, "R8");
    do_req(2, 0, 0, "R5");
    do_req(3, 0, 0, "R6");
    do_req(1, 0, 10, "R4");
    do_req(2, 0, 0, "R5");
    do_req(2, 0, 0, "R5");
    do_req(2, 0, 0, "R5");
    do_req(2, 0, 0, "R8");
    do_req(3, 1, 0, "R8");
    do_req(4, 0, 0, "R7");
    do_req(4, 0, 0, "R8");
    do_req(2, 0, 0, "R8");
    do_req(0, 3, 0, "R3");
    do_req(2, 0, 0, "R8");
    do_req(4, 0, 0, "R8");
    do_req(0, 0, 11, "R3");
    do_req(3, 4, 0, "R8");
    do_req(3, 2, 0, "R6");
    do_req(4, 0, 0, "R7");
    repeat (4) @(negedge clk);
    check("R3", "stream queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule